// File: doc/BRIEF.md
# Translation Lookaside Buffer with Accessed and Dirty Tracking

This block is a small fully associative translation cache that sits between a load/store unit and the memory system. Each slot holds a virtual page number, a physical frame number, two permission flags and a local copy of the page's accessed and dirty bits. A lookup carries a virtual address and a load/store type. One cycle later the block reports one of three outcomes. A hit returns the physical address. A permission violation returns a fault. A miss returns the virtual page number so that an external walker can fetch the translation.

The block only trusts its own cached accessed and dirty bits. When a permitted hit finds that the accessed bit is clear, or that a store targets a page whose dirty bit is clear, it raises a request to an external page-table writer. It holds that request, withholds the result and refuses new lookups until the writer acknowledges. The cached bits are then set and the result is released. A bit that is already set in the cache is never rechecked against memory. Only a flush or a refill brings the cache back in line with the page table.

New translations enter through a refill port. Refill slots are chosen in round-robin order, except that a refill of a page already held replaces that slot in place. Software can drop every slot or a single page through the two flush inputs.

Top module: `xlat_buf`

## Requirements
- R1: A lookup presented while `lk_ready` is high produces `res_valid` in the next cycle. On a permitted hit that needs no update, `res_hit` is 1 and `res_paddr` is the slot's frame number in the upper bits with the lookup's 12-bit page offset in the lower bits. `res_a` and `res_d` carry the slot's cached bits.
- R2: A lookup whose page is in no valid slot returns `res_miss`=1, `res_hit`=0, `res_paddr`=0, and `res_vpn` equal to the looked-up page number.
- R3: `perm` bit 0 grants reads and bit 1 grants writes. A load on a hit slot without bit 0, or a store on a hit slot without bit 1, returns `res_fault`=1 with `res_paddr`=0 and raises no update request.
- R4: A permitted load hit on a slot whose accessed bit is 0 raises `upd_req` in the cycle the result would otherwise appear, with `upd_set_a`=1 and `upd_set_d`=0. In that cycle and until the acknowledge, `res_valid` is 0 and `lk_ready` is 0.
- R5: A permitted store hit on a slot whose dirty bit is 0 raises `upd_req` with `upd_set_d`=1, and with `upd_set_a` equal to the inverse of the cached accessed bit.
- R6: The cycle after `upd_ack` is sampled high, `upd_req` drops and the held result appears as a hit with `res_a`=1 and the dirty bit updated. Later lookups of that page see the bits set and raise no request.
- R7: A permitted hit whose needed bits are already 1 raises no update request, whatever the page table in memory holds.
- R8: While `upd_ack` is low, `upd_req`, `upd_vpn`, `upd_set_a` and `upd_set_d` stay unchanged.
- R9: Refills of pages not already held fill slots in round-robin order starting at slot 0, so the ninth new page evicts the first. A refill of a page already held overwrites that slot and does not advance the order.
- R10: Asserting `flush_all` makes every lookup presented in the following cycles miss until new refills arrive.
- R11: Asserting `flush_one` removes only the slot holding `flush_vpn`. Other slots keep hitting.
- R12: After reset all slots are invalid, `res_valid` and `upd_req` are 0, and `lk_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_store | input | 1 | 1 for a store, 0 for a load |
| lk_ready | output | 1 | Lookups accepted when high |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Translation returned |
| res_miss | output | 1 | Page not held |
| res_fault | output | 1 | Permission violation |
| res_vpn | output | 20 | Virtual page number of the result |
| res_paddr | output | 32 | Physical address, 0 unless hit |
| res_perm | output | 2 | Permission flags of the hit slot |
| res_a | output | 1 | Accessed bit after the access |
| res_d | output | 1 | Dirty bit after the access |
| upd_req | output | 1 | Page-table bit update request |
| upd_vpn | output | 20 | Page to update |
| upd_set_a | output | 1 | Accessed bit must be set |
| upd_set_d | output | 1 | Dirty bit must be set |
| upd_ack | input | 1 | Update performed |
| fill_valid | input | 1 | Refill strobe |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_pfn | input | 20 | Refill physical frame number |
| fill_perm | input | 2 | Refill permission flags |
| fill_a | input | 1 | Refill accessed bit |
| fill_d | input | 1 | Refill dirty bit |
| flush_all | input | 1 | Invalidate every slot |
| flush_one | input | 1 | Invalidate the slot holding flush_vpn |
| flush_vpn | input | 20 | Page to invalidate |

## Verification
Every lookup result is registered once. It is due in the cycle after the lookup is sampled, and an update request takes its place in that same cycle. A held result is due in the cycle after the acknowledge is sampled. Refills and flushes change the contents at the sampling edge, so a lookup presented in the following cycle sees them. The bench drives all inputs on the falling edge and checks outputs on the next falling edge, exactly one register stage after the edge that captured the stimulus. It holds the acknowledge low for several cycles to observe that the request stays stable.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int DEF_VPN_W  = 20;
  localparam int DEF_OFF_W  = 12;
  localparam int DEF_PFN_W  = 20;
  localparam int DEF_SLOTS  = 8;
  localparam int PERM_BITS  = 2;
  localparam int PERM_READ  = 0;
  localparam int PERM_WRITE = 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } upd_state_e;
endpackage

// File: rtl/xlat_rr.sv
module xlat_rr #(
  parameter int SLOTS = 8,
  localparam int IW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  logic [IW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      if (ptr_q == IW'(SLOTS - 1)) ptr_d = '0;
      else                         ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R9: the replacement order only moves on a refill of a new page
  p_rr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q));
endmodule

// File: rtl/xlat_tags.sv
module xlat_tags #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int PERM_W = 2,
  parameter int SLOTS = 8,
  localparam int IW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  look_vpn,
  output logic              hit,
  output logic [PFN_W-1:0]  hit_pfn,
  output logic [PERM_W-1:0] hit_perm,
  output logic              hit_a,
  output logic              hit_d,
  output logic [IW-1:0]     hit_idx,
  input  logic [VPN_W-1:0]  fill_vpn,
  output logic              fill_found,
  output logic [IW-1:0]     fill_found_idx,
  input  logic              fill_en,
  input  logic [IW-1:0]     fill_idx,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              fill_a,
  input  logic              fill_d,
  input  logic              flush_all,
  input  logic              flush_one,
  input  logic [VPN_W-1:0]  flush_vpn,
  input  logic              set_en,
  input  logic [IW-1:0]     set_idx,
  input  logic              set_a,
  input  logic              set_d
);
  logic [SLOTS-1:0]  look_match;
  logic [SLOTS-1:0]  fill_match;
  logic [SLOTS-1:0]  valid_vec;
  logic [PFN_W-1:0]  pfn_arr  [SLOTS];
  logic [PERM_W-1:0] perm_arr [SLOTS];
  logic [SLOTS-1:0]  a_vec;
  logic [SLOTS-1:0]  d_vec;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic              v_q, v_d;
    logic [VPN_W-1:0]  vpn_q;
    logic [PFN_W-1:0]  pfn_q;
    logic [PERM_W-1:0] perm_q;
    logic              a_q, a_d, d_q, d_d;
    logic              load_fill, load_set, drop;

    assign load_fill = fill_en && (fill_idx == IW'(i));
    assign load_set  = set_en && (set_idx == IW'(i));
    assign drop      = flush_all || (flush_one && v_q && (vpn_q == flush_vpn));

    always_comb begin
      v_d = v_q;
      a_d = a_q;
      d_d = d_q;
      if (load_set) begin
        a_d = a_q | set_a;
        d_d = d_q | set_d;
      end
      if (load_fill) begin
        v_d = 1'b1;
        a_d = fill_a;
        d_d = fill_d;
      end
      if (drop) v_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (load_fill) begin
        vpn_q  <= fill_vpn;
        pfn_q  <= fill_pfn;
        perm_q <= fill_perm;
      end
      if (load_fill || load_set) begin
        a_q <= a_d;
        d_q <= d_d;
      end
    end

    assign look_match[i] = v_q && (vpn_q == look_vpn);
    assign fill_match[i] = v_q && (vpn_q == fill_vpn);
    assign valid_vec[i]  = v_q;
    assign pfn_arr[i]    = pfn_q;
    assign perm_arr[i]   = perm_q;
    assign a_vec[i]      = a_q;
    assign d_vec[i]      = d_q;
  end

  always_comb begin
    hit_idx        = '0;
    fill_found_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (look_match[i]) hit_idx        = hit_idx | IW'(i);
      if (fill_match[i]) fill_found_idx = fill_found_idx | IW'(i);
    end
  end

  assign hit        = |look_match;
  assign fill_found = |fill_match;
  assign hit_pfn    = pfn_arr[hit_idx];
  assign hit_perm   = perm_arr[hit_idx];
  assign hit_a      = a_vec[hit_idx];
  assign hit_d      = d_vec[hit_idx];

  // R9: in-place refill keeps every page in at most one slot
  p_unique_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match));

  // R10: a flush-all empties every slot by the next cycle
  p_flush_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));

  // R6: an acknowledged update leaves the accessed bit set
  p_set_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_a && !fill_en) |=> a_vec[$past(set_idx)]);
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20,
  parameter int PERM_W = 2,
  parameter int SLOTS = 8,
  localparam int IW = $clog2(SLOTS),
  localparam int PA_W = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [OFF_W-1:0]  lk_off,
  input  logic              lk_store,
  output logic              lk_ready,
  input  logic              hit,
  input  logic [PFN_W-1:0]  hit_pfn,
  input  logic [PERM_W-1:0] hit_perm,
  input  logic              hit_a,
  input  logic              hit_d,
  input  logic [IW-1:0]     hit_idx,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_fault,
  output logic [VPN_W-1:0]  res_vpn,
  output logic [PA_W-1:0]   res_paddr,
  output logic [PERM_W-1:0] res_perm,
  output logic              res_a,
  output logic              res_d,
  output logic              upd_req,
  output logic [VPN_W-1:0]  upd_vpn,
  output logic              upd_set_a,
  output logic              upd_set_d,
  input  logic              upd_ack,
  output logic              set_en,
  output logic [IW-1:0]     set_idx
);
  upd_state_e st_q, st_d;

  logic [VPN_W-1:0]  pend_vpn;
  logic [IW-1:0]     pend_idx;
  logic [PFN_W-1:0]  pend_pfn;
  logic [OFF_W-1:0]  pend_off;
  logic [PERM_W-1:0] pend_perm;
  logic              pend_d, pend_sa, pend_sd;
  logic              go_wait;

  logic              rv_q, rv_d;
  logic              r_hit, r_miss, r_fault, r_a, r_d;
  logic [VPN_W-1:0]  r_vpn;
  logic [PA_W-1:0]   r_paddr;
  logic [PERM_W-1:0] r_perm;

  logic fault, need_a, need_d;

  assign fault  = lk_store ? !hit_perm[PERM_WRITE] : !hit_perm[PERM_READ];
  assign need_a = !hit_a;
  assign need_d = lk_store && !hit_d;

  always_comb begin
    st_d    = st_q;
    go_wait = 1'b0;
    rv_d    = 1'b0;
    r_hit   = 1'b0;
    r_miss  = 1'b0;
    r_fault = 1'b0;
    r_paddr = '0;
    r_perm  = '0;
    r_a     = 1'b0;
    r_d     = 1'b0;
    r_vpn   = lk_vpn;
    case (st_q)
      ST_IDLE: begin
        if (lk_valid) begin
          if (!hit) begin
            rv_d   = 1'b1;
            r_miss = 1'b1;
          end else if (fault) begin
            rv_d    = 1'b1;
            r_fault = 1'b1;
            r_perm  = hit_perm;
            r_a     = hit_a;
            r_d     = hit_d;
          end else if (need_a || need_d) begin
            st_d    = ST_WAIT;
            go_wait = 1'b1;
          end else begin
            rv_d    = 1'b1;
            r_hit   = 1'b1;
            r_paddr = {hit_pfn, lk_off};
            r_perm  = hit_perm;
            r_a     = hit_a;
            r_d     = hit_d;
          end
        end
      end
      ST_WAIT: begin
        r_vpn = pend_vpn;
        if (upd_ack) begin
          st_d    = ST_IDLE;
          rv_d    = 1'b1;
          r_hit   = 1'b1;
          r_paddr = {pend_pfn, pend_off};
          r_perm  = pend_perm;
          r_a     = 1'b1;
          r_d     = pend_d | pend_sd;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (go_wait) begin
      pend_vpn  <= lk_vpn;
      pend_idx  <= hit_idx;
      pend_pfn  <= hit_pfn;
      pend_off  <= lk_off;
      pend_perm <= hit_perm;
      pend_d    <= hit_d;
      pend_sa   <= need_a;
      pend_sd   <= need_d;
    end
    if (rv_d) begin
      res_hit   <= r_hit;
      res_miss  <= r_miss;
      res_fault <= r_fault;
      res_vpn   <= r_vpn;
      res_paddr <= r_paddr;
      res_perm  <= r_perm;
      res_a     <= r_a;
      res_d     <= r_d;
    end
  end

  assign res_valid = rv_q;
  assign lk_ready  = (st_q == ST_IDLE);
  assign upd_req   = (st_q == ST_WAIT);
  assign upd_vpn   = pend_vpn;
  assign upd_set_a = pend_sa;
  assign upd_set_d = pend_sd;
  assign set_en    = (st_q == ST_WAIT) && upd_ack;
  assign set_idx   = pend_idx;

  // R8: the request is held steady until it is acknowledged
  p_req_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req && !upd_ack) |=> (upd_req && $stable(upd_vpn) &&
                               $stable(upd_set_a) && $stable(upd_set_d)));

  // R4: no result and no new lookup while a request is outstanding
  p_hold_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |-> (!res_valid && !lk_ready));

  // R6: the held result follows the acknowledge by one cycle
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req && upd_ack) |=> (res_valid && res_hit && res_a && !upd_req));

  // R2: a miss never carries an address
  p_miss_no_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss) |-> (res_paddr == '0 && !res_hit));

  // R3: a fault never carries an address
  p_fault_no_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_paddr == '0 && !res_hit));
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int VPN_W = DEF_VPN_W,
  parameter int OFF_W = DEF_OFF_W,
  parameter int PFN_W = DEF_PFN_W,
  parameter int SLOTS = DEF_SLOTS,
  localparam int PERM_W = PERM_BITS,
  localparam int VA_W = VPN_W + OFF_W,
  localparam int PA_W = PFN_W + OFF_W,
  localparam int IW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_store,
  output logic              lk_ready,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_fault,
  output logic [VPN_W-1:0]  res_vpn,
  output logic [PA_W-1:0]   res_paddr,
  output logic [PERM_W-1:0] res_perm,
  output logic              res_a,
  output logic              res_d,
  output logic              upd_req,
  output logic [VPN_W-1:0]  upd_vpn,
  output logic              upd_set_a,
  output logic              upd_set_d,
  input  logic              upd_ack,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              fill_a,
  input  logic              fill_d,
  input  logic              flush_all,
  input  logic              flush_one,
  input  logic [VPN_W-1:0]  flush_vpn
);
  logic [VPN_W-1:0]  lk_vpn;
  logic [OFF_W-1:0]  lk_off;
  logic              hit, hit_a, hit_d;
  logic [PFN_W-1:0]  hit_pfn;
  logic [PERM_W-1:0] hit_perm;
  logic [IW-1:0]     hit_idx;
  logic              fill_found;
  logic [IW-1:0]     fill_found_idx, rr_ptr, fill_idx;
  logic              set_en;
  logic [IW-1:0]     set_idx;

  assign lk_vpn   = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off   = lk_vaddr[OFF_W-1:0];
  assign fill_idx = fill_found ? fill_found_idx : rr_ptr;

  xlat_rr #(.SLOTS(SLOTS)) u_rr (
    .clk (clk),
    .rst_n (rst_n),
    .adv (fill_valid && !fill_found),
    .ptr (rr_ptr)
  );

  xlat_tags #(
    .VPN_W(VPN_W), .PFN_W(PFN_W), .PERM_W(PERM_W), .SLOTS(SLOTS)
  ) u_tags (
    .clk            (clk),
    .rst_n          (rst_n),
    .look_vpn       (lk_vpn),
    .hit            (hit),
    .hit_pfn        (hit_pfn),
    .hit_perm       (hit_perm),
    .hit_a          (hit_a),
    .hit_d          (hit_d),
    .hit_idx        (hit_idx),
    .fill_vpn       (fill_vpn),
    .fill_found     (fill_found),
    .fill_found_idx (fill_found_idx),
    .fill_en        (fill_valid),
    .fill_idx       (fill_idx),
    .fill_pfn       (fill_pfn),
    .fill_perm      (fill_perm),
    .fill_a         (fill_a),
    .fill_d         (fill_d),
    .flush_all      (flush_all),
    .flush_one      (flush_one),
    .flush_vpn      (flush_vpn),
    .set_en         (set_en),
    .set_idx        (set_idx),
    .set_a          (upd_set_a),
    .set_d          (upd_set_d)
  );

  xlat_ctrl #(
    .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .PERM_W(PERM_W), .SLOTS(SLOTS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vpn    (lk_vpn),
    .lk_off    (lk_off),
    .lk_store  (lk_store),
    .lk_ready  (lk_ready),
    .hit       (hit),
    .hit_pfn   (hit_pfn),
    .hit_perm  (hit_perm),
    .hit_a     (hit_a),
    .hit_d     (hit_d),
    .hit_idx   (hit_idx),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_miss  (res_miss),
    .res_fault (res_fault),
    .res_vpn   (res_vpn),
    .res_paddr (res_paddr),
    .res_perm  (res_perm),
    .res_a     (res_a),
    .res_d     (res_d),
    .upd_req   (upd_req),
    .upd_vpn   (upd_vpn),
    .upd_set_a (upd_set_a),
    .upd_set_d (upd_set_d),
    .upd_ack   (upd_ack),
    .set_en    (set_en),
    .set_idx   (set_idx)
  );

  // R12: out of reset the block accepts lookups and has nothing pending
  p_reset_idle_r12: assert property (@(posedge clk)
    $rose(rst_n) |-> (lk_ready && !upd_req && !res_valid));
endmodule

// File: tb/xlat_buf_bench.sv
module xlat_buf_bench;
  localparam int K_HIT = 0, K_MISS = 1, K_FAULT = 2, K_UPD = 3;

  typedef struct packed {
    logic [19:0] vpn;
    logic [11:0] off;
    logic        st;
    logic [1:0]  kind;
    logic        sa;
    logic        sd;
    logic        ea;
    logic        ed;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{20'h10, 12'h123, 1'b0, 2'(K_HIT),   1'b0, 1'b0, 1'b1, 1'b1},
    '{20'h17, 12'hFFF, 1'b1, 2'(K_HIT),   1'b0, 1'b0, 1'b1, 1'b1},
    '{20'h99, 12'h004, 1'b0, 2'(K_MISS),  1'b0, 1'b0, 1'b0, 1'b0},
    '{20'h12, 12'h010, 1'b1, 2'(K_FAULT), 1'b0, 1'b0, 1'b0, 1'b0},
    '{20'h14, 12'h020, 1'b0, 2'(K_FAULT), 1'b0, 1'b0, 1'b0, 1'b0},
    '{20'h15, 12'h030, 1'b0, 2'(K_FAULT), 1'b0, 1'b0, 1'b0, 1'b0},
    '{20'h15, 12'h031, 1'b1, 2'(K_HIT),   1'b0, 1'b0, 1'b1, 1'b1},
    '{20'h11, 12'h400, 1'b0, 2'(K_UPD),   1'b1, 1'b0, 1'b1, 1'b0},
    '{20'h11, 12'h401, 1'b0, 2'(K_HIT),   1'b0, 1'b0, 1'b1, 1'b0},
    '{20'h11, 12'h402, 1'b1, 2'(K_UPD),   1'b0, 1'b1, 1'b1, 1'b1},
    '{20'h16, 12'h555, 1'b1, 2'(K_UPD),   1'b1, 1'b1, 1'b1, 1'b1},
    '{20'h13, 12'h0AA, 1'b1, 2'(K_UPD),   1'b0, 1'b1, 1'b1, 1'b1},
    '{20'h13, 12'h0AB, 1'b1, 2'(K_HIT),   1'b0, 1'b0, 1'b1, 1'b1},
    '{20'h12, 12'h000, 1'b0, 2'(K_HIT),   1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_store, lk_ready;
  logic [31:0] lk_vaddr;
  logic        res_valid, res_hit, res_miss, res_fault, res_a, res_d;
  logic [19:0] res_vpn;
  logic [31:0] res_paddr;
  logic [1:0]  res_perm;
  logic        upd_req, upd_set_a, upd_set_d, upd_ack;
  logic [19:0] upd_vpn;
  logic        fill_valid, fill_a, fill_d;
  logic [19:0] fill_vpn, fill_pfn;
  logic [1:0]  fill_perm;
  logic        flush_all, flush_one;
  logic [19:0] flush_vpn;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  xlat_buf u_xlat_buf (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_store(lk_store), .lk_ready(lk_ready),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
    .res_vpn(res_vpn), .res_paddr(res_paddr), .res_perm(res_perm), .res_a(res_a), .res_d(res_d),
    .upd_req(upd_req), .upd_vpn(upd_vpn), .upd_set_a(upd_set_a), .upd_set_d(upd_set_d),
    .upd_ack(upd_ack),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .fill_a(fill_a), .fill_d(fill_d),
    .flush_all(flush_all), .flush_one(flush_one), .flush_vpn(flush_vpn)
  );

  function automatic logic [19:0] pfn_of(input logic [19:0] vpn);
    return 20'h800 + (vpn - 20'h10) * 3;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [1:0] perm,
                      input logic a, input logic d);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm; fill_a = a; fill_d = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic st);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_store = st;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [19:0] pfn, input logic [11:0] off);
    chk(res_valid && res_hit && !res_miss && !res_fault, tag,
        {res_valid, res_hit, res_miss, res_fault}, 4'b1100);
    chk(res_paddr == {pfn, off}, tag, res_paddr, {pfn, off});
  endtask

  task automatic expect_miss(input string tag, input logic [19:0] vpn);
    chk(res_valid && res_miss && !res_hit && res_paddr == 32'h0 && res_vpn == vpn, tag,
        {res_valid, res_miss, res_hit, res_vpn}, {3'b110, vpn});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_valid = 1'b0; lk_vaddr = '0; lk_store = 1'b0; upd_ack = 1'b0;
    fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_perm = '0; fill_a = 1'b0; fill_d = 1'b0;
    flush_all = 1'b0; flush_one = 1'b0; flush_vpn = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!res_valid && !upd_req && lk_ready, "R12",
        {res_valid, upd_req, lk_ready}, 3'b001);
    rst_n = 1'b1;
    look(20'h10, 12'h0, 1'b0);
    expect_miss("R12", 20'h10);

    // slots 0..7: pages 0x10..0x17 with varied flags
    for (int i = 0; i < 8; i++) begin
      logic [1:0] perm;
      logic a, d;
      perm = (i == 2) ? 2'b01 : (i == 4) ? 2'b00 : (i == 5) ? 2'b10 : 2'b11;
      a = !(i == 1 || i == 6);
      d = (i == 0 || i == 4 || i == 5 || i == 7);
      fill(20'h10 + 20'(i), pfn_of(20'h10 + 20'(i)), perm, a, d);
    end

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = TBL[v];
      look(t.vpn, t.off, t.st);
      case (int'(t.kind))
        K_HIT: begin
          expect_hit("R1", pfn_of(t.vpn), t.off);
          chk(res_a == t.ea && res_d == t.ed, "R1", {res_a, res_d}, {t.ea, t.ed});
          chk(!upd_req && lk_ready, "R7", upd_req, 1'b0);
        end
        K_MISS: expect_miss("R2", t.vpn);
        K_FAULT: begin
          chk(res_valid && res_fault && !res_hit && res_paddr == 32'h0, "R3",
              {res_valid, res_fault, res_hit, res_paddr}, {3'b110, 32'h0});
          chk(!upd_req, "R3", upd_req, 1'b0);
        end
        default: begin
          chk(upd_req && !res_valid && !lk_ready, t.st ? "R5" : "R4",
              {upd_req, res_valid, lk_ready}, 3'b100);
          chk(upd_vpn == t.vpn && upd_set_a == t.sa && upd_set_d == t.sd, t.st ? "R5" : "R4",
              {upd_vpn, upd_set_a, upd_set_d}, {t.vpn, t.sa, t.sd});
          repeat (3) begin
            @(negedge clk);
            chk(upd_req && upd_vpn == t.vpn && upd_set_a == t.sa && upd_set_d == t.sd &&
                !res_valid, "R8", {upd_req, upd_vpn}, {1'b1, t.vpn});
          end
          upd_ack = 1'b1;
          @(negedge clk);
          upd_ack = 1'b0;
          chk(!upd_req, "R6", upd_req, 1'b0);
          expect_hit("R6", pfn_of(t.vpn), t.off);
          chk(res_a == t.ea && res_d == t.ed, "R6", {res_a, res_d}, {t.ea, t.ed});
        end
      endcase
    end

    // R9: in-place refill, then round-robin eviction of slot 0
    fill(20'h12, 20'h555, 2'b11, 1'b1, 1'b1);
    look(20'h12, 12'h321, 1'b1);
    expect_hit("R9", 20'h555, 12'h321);
    fill(20'h40, 20'h0ABC, 2'b11, 1'b1, 1'b1);
    look(20'h10, 12'h0, 1'b0);
    expect_miss("R9", 20'h10);
    look(20'h40, 12'h7, 1'b0);
    expect_hit("R9", 20'h0ABC, 12'h7);
    look(20'h11, 12'h8, 1'b0);
    expect_hit("R9", pfn_of(20'h11), 12'h8);

    // R11: single-page flush
    @(negedge clk);
    flush_one = 1'b1; flush_vpn = 20'h13;
    @(negedge clk);
    flush_one = 1'b0;
    look(20'h13, 12'h0, 1'b0);
    expect_miss("R11", 20'h13);
    look(20'h17, 12'h9, 1'b0);
    expect_hit("R11", pfn_of(20'h17), 12'h9);

    // R10: flush everything
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    look(20'h17, 12'h0, 1'b0);
    expect_miss("R10", 20'h17);
    look(20'h40, 12'h0, 1'b0);
    expect_miss("R10", 20'h40);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule